// File: doc/BRIEF.md
# Serial Shift Transfer Engine

This block runs one serial data command at a time on a three-wire link made of a clock, a data output and a data input. A dispatcher pulses `start` with an opcode whose low six bits choose the options. The engine then takes the length bytes and any outgoing payload from a command FIFO, shifts the bits on the serial lines, and pushes any captured bytes into a response FIFO. Each opcode option is independent of the others: output on or off, input on or off, which clock edge changes the output, which clock edge samples the input, LSB-first or MSB-first order, and whether the length counts bytes or bits.

The serial clock is built from a divisor tick that the dispatcher supplies. A long byte-mode transfer streams up to 65536 bytes with no gap inside a byte. If the command FIFO has no payload ready, or the response FIFO has no room, the engine waits between bytes with the clock low.

Top module: `shift_xfer_engine`

## Requirements
- R1: While reset is asserted `sclk`, `sdo`, `busy`, `done`, `cmd_pop` and `rsp_push` are all low.
- R2: When opcode bit 1 is 0 (byte mode), the engine pops two length bytes from the command FIFO, low byte first, giving L. It then transfers L+1 bytes. L=0 moves one byte and L=0x0100 moves 257 bytes.
- R3: When opcode bit 1 is 1 (bit mode), the engine pops one length byte and moves (its bits [2:0]) + 1 bits, from 1 to 8. Bits [7:3] of that byte are ignored.
- R4: `sclk` is low whenever the engine is idle. It changes only in the cycle after a `tick`. Each transferred bit gives exactly one rising edge and one falling edge, so one bit takes two ticks.
- R5: When opcode bit 0 is 1, `sdo` never changes on a rising `sclk` edge. When bit 0 is 0, `sdo` changes only on rising `sclk` edges.
- R6: When opcode bit 2 is 1, `sdi` is sampled on falling `sclk` edges. When bit 2 is 0, it is sampled on rising edges.
- R7: When opcode bit 3 is 1, each byte goes out and comes in LSB first. When bit 3 is 0, it goes MSB first.
- R8: When opcode bit 4 is 1, the command pops one payload byte per transferred byte (one byte in bit mode) after the length. When bit 4 is 0, no payload is popped and `sdo` stays low for the whole command.
- R9: When opcode bit 5 is 1, the engine pushes one response byte for each byte moved (one byte in bit mode). When bit 5 is 0, it pushes nothing.
- R10: In bit mode with input enabled, the response byte holds the n captured bits right-aligned for MSB-first order and left-aligned for LSB-first order. The first bit captured is the most significant of the n bits in MSB-first order and the least significant in LSB-first order. All other bits are 0.
- R11: If the command FIFO is empty when payload is due, or the response FIFO is full when a byte is ready, the engine waits with `sclk` low. No bit is lost or repeated.
- R12: `busy` is high from the cycle after an accepted `start` until the command ends. `done` pulses for one cycle at the end. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command using `opcode` |
| opcode | input | 8 | Command option bits; bits 0 to 5 are used |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| tick | input | 1 | Divisor tick; each one advances the serial clock by half a period |
| cmd_valid | input | 1 | Command FIFO holds a byte |
| cmd_data | input | DW | Head byte of the command FIFO |
| cmd_pop | output | 1 | Consume the head byte of the command FIFO |
| rsp_full | input | 1 | Response FIFO has no room |
| rsp_data | output | DW | Captured byte for the response FIFO |
| rsp_push | output | 1 | Write `rsp_data` into the response FIFO |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest conditions to reach are a FIFO stall that falls between two bytes of a running transfer, and an input sample taken on the wrong clock edge.

For stalls, the bench gates `cmd_valid` and `rsp_full` from a free-running counter. Starvation and back-pressure therefore land on different byte boundaries during a six-byte duplex command, and the captured and emitted bit streams are compared bit by bit.

For the sample edge, the bench's serial device changes `sdi` at the same clock edge where the engine is meant to sample. A sample taken on the opposite edge would pick up the neighbouring bit.

A second `start` is also raised in the middle of a transfer, with input enabled, to show that it is ignored.

// File: rtl/shift_xfer_engine.sv
module shift_xfer_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  output logic          busy,
  output logic          done,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [DW-1:0] cmd_data,
  output logic          cmd_pop,
  input  logic          rsp_full,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_push,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi
);
  localparam int CW = $clog2(DW + 1);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {IDLE, LEN_LO, LEN_HI, LOAD, SHIFT, PUSH} st_t;
  st_t st;

  logic [5:0]      op;
  logic [2*DW-1:0] left;
  logic [CW-1:0]   chunk, bcnt;
  logic [DW-1:0]   osh, ish;
  logic            ph;

  wire fall_out = op[0];
  wire bit_mode = op[1];
  wire fall_in  = op[2];
  wire lsb      = op[3];
  wire out_en   = op[4];
  wire in_en    = op[5];
  wire last     = left == '0;

  wire [DW-1:0] load_d  = out_en ? cmd_data : '0;
  wire          lbit    = lsb ? load_d[0] : load_d[DW-1];
  wire [DW-1:0] load_nx = lsb ? load_d >> 1 : load_d << 1;
  wire          obit    = lsb ? osh[0] : osh[DW-1];
  wire [DW-1:0] osh_nx  = lsb ? osh >> 1 : osh << 1;
  wire [DW-1:0] ish_nx  = lsb ? {sdi, ish[DW-1:1]} : {ish[DW-2:0], sdi};

  assign busy     = st != IDLE;
  assign cmd_pop  = cmd_valid && (st == LEN_LO || st == LEN_HI || (st == LOAD && out_en));
  assign rsp_push = st == PUSH && !rsp_full;
  assign rsp_data = ish;

  wire load_go   = st == LOAD && (!out_en || cmd_valid);
  wire byte_end  = st == SHIFT && tick && ph && bcnt == CW'(1);
  wire chunk_end = (byte_end && !in_en) || rsp_push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; op <= '0; left <= '0; chunk <= '0; bcnt <= '0;
      osh <= '0; ish <= '0; ph <= 1'b0; sclk <= 1'b0; sdo <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          op <= opcode[5:0];
          if (!opcode[4]) sdo <= 1'b0;
          st <= LEN_LO;
        end
        LEN_LO: if (cmd_valid) begin
          if (bit_mode) begin
            left  <= '0;
            chunk <= CW'(cmd_data[BW-1:0]) + CW'(1);
            st    <= LOAD;
          end else begin
            left[DW-1:0] <= cmd_data;
            chunk        <= CW'(DW);
            st           <= LEN_HI;
          end
        end
        LEN_HI: if (cmd_valid) begin
          left[2*DW-1:DW] <= cmd_data;
          st <= LOAD;
        end
        LOAD: if (load_go) begin
          ish  <= '0;
          bcnt <= chunk;
          ph   <= 1'b0;
          st   <= SHIFT;
          if (fall_out) begin
            sdo <= lbit;
            osh <= load_nx;
          end else osh <= load_d;
        end
        SHIFT: if (tick) begin
          ph   <= !ph;
          sclk <= !ph;
          if (!ph) begin
            if (!fall_out) begin
              sdo <= obit;
              osh <= osh_nx;
            end
            if (!fall_in) ish <= ish_nx;
          end else begin
            if (fall_in) ish <= ish_nx;
            bcnt <= bcnt - CW'(1);
            if (fall_out && bcnt != CW'(1)) begin
              sdo <= obit;
              osh <= osh_nx;
            end
            if (bcnt == CW'(1)) st <= in_en ? PUSH : (last ? IDLE : LOAD);
          end
        end
        PUSH: if (!rsp_full) st <= last ? IDLE : LOAD;
        default: st <= IDLE;
      endcase
      if (chunk_end) begin
        if (last) done <= 1'b1;
        else left <= left - 1'b1;
      end
    end
  end
endmodule

module shift_xfer_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic cmd_valid,
  input logic cmd_pop,
  input logic rsp_full,
  input logic rsp_push
);
  // R4
  sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));
  // R4
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R11
  pop_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid);
  // R11
  push_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_push |-> !rsp_full);
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind shift_xfer_engine shift_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(sclk), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .rsp_full(rsp_full), .rsp_push(rsp_push)
);

// File: tb/tb_shift_xfer_engine.sv
module tb_shift_xfer_engine;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic busy, done, tick, cmd_valid, cmd_pop, rsp_full, rsp_push, sclk, sdo, sdi;
  logic [7:0] cmd_data, rsp_data;

  logic [7:0] cmem [0:4095];
  logic [7:0] rmem [0:4095];
  logic       sbits[0:4095];
  logic       rxbits[0:4095];
  int ccnt = 0, crd = 0, rcnt = 0, sidx = 0, rxn = 0;
  logic s_icn = 1'b0, s_ocn = 1'b0, stall_cmd = 1'b0, stall_rsp = 1'b0, tc = 1'b0;
  logic [7:0] sc = 8'h00;
  int rise_cnt = 0, rise_chg = 0, fall_chg = 0, idle_chg = 0, sdo_hi = 0, done_cnt = 0;
  logic psclk = 1'b0, psdo = 1'b0;
  int checks = 0, errors = 0;

  shift_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .busy(busy), .done(done),
    .tick(tick), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .rsp_full(rsp_full), .rsp_data(rsp_data), .rsp_push(rsp_push),
    .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  always #(CLK_P/2) clk = ~clk;

  assign tick      = tc;
  assign cmd_valid = (crd < ccnt) && !(stall_cmd && sc[4]);
  assign cmd_data  = cmem[crd[11:0]];
  assign rsp_full  = stall_rsp && sc[3];
  assign sdi       = sbits[sidx[11:0]];

  always @(posedge clk) begin
    tc <= ~tc;
    sc <= sc + 8'd1;
    if (cmd_pop) crd <= crd + 1;
    if (rsp_push) begin
      rmem[rcnt[11:0]] <= rsp_data;
      rcnt <= rcnt + 1;
    end
  end

  always @(sclk) begin
    if ((sclk === 1'b1 && !s_icn) || (sclk === 1'b0 && s_icn)) sidx <= sidx + 1;
    if ((sclk === 1'b1 && s_ocn) || (sclk === 1'b0 && !s_ocn)) begin
      rxbits[rxn[11:0]] <= sdo;
      rxn <= rxn + 1;
    end
  end

  always @(negedge clk) begin
    if (sclk === 1'b1 && psclk === 1'b0) rise_cnt <= rise_cnt + 1;
    if (sdo !== psdo) begin
      if (sclk !== psclk) begin
        if (sclk === 1'b1) rise_chg <= rise_chg + 1;
        else fall_chg <= fall_chg + 1;
      end else idle_chg <= idle_chg + 1;
    end
    if (busy === 1'b1 && sdo === 1'b1) sdo_hi <= sdo_hi + 1;
    if (done === 1'b1) done_cnt <= done_cnt + 1;
    psclk <= sclk;
    psdo  <= sdo;
  end

  function automatic logic [7:0] pat(int s, int k);
    return 8'((s * 29 + k * 53 + 60) ^ (k * 8));
  endfunction

  function automatic logic sbit(int s, int k);
    return ((k * 3 + s) % 7) < 3;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [15:0] len, input int seed,
                        input string lab, input bit poke);
    int nb, nch, cb, rb, sb, xb, w, n, bad, fa, fe;
    int r0, rc0, fc0, ic0, sh0, d0;
    string lab_cnt;
    logic [7:0] e, p;
    nb  = op[1] ? int'(len[2:0]) + 1 : 8;
    nch = op[1] ? 1 : int'(len) + 1;
    lab_cnt = op[1] ? "R3" : "R2";
    cb = ccnt; rb = rcnt; sb = sidx; xb = rxn;
    r0 = rise_cnt; rc0 = rise_chg; fc0 = fall_chg; ic0 = idle_chg; sh0 = sdo_hi; d0 = done_cnt;
    w = cb;
    cmem[w[11:0]] = len[7:0]; w++;
    if (!op[1]) begin cmem[w[11:0]] = len[15:8]; w++; end
    if (op[4]) for (int c = 0; c < nch; c++) begin cmem[w[11:0]] = pat(seed, c); w++; end
    for (int k = 0; k < nch * nb; k++) sbits[(sb + k) % 4096] = sbit(seed, k);
    s_icn = op[2];
    s_ocn = op[0];
    ccnt = w;
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 60000) begin
      @(negedge clk);
      n++;
      if (poke && n == 30) begin start = 1'b1; opcode = 8'h2B; end
      else start = 1'b0;
    end
    start = 1'b0;
    if (n >= 60000) chk(1'b0, "R12", "done never seen", n, 0);
    repeat (3) @(negedge clk);
    chk(rise_cnt - r0 == nch * nb, "R4", "rising sclk edges", rise_cnt - r0, nch * nb);
    chk(crd == ccnt, lab_cnt, "command bytes popped", crd - cb, ccnt - cb);
    chk(rcnt - rb == (op[5] ? nch : 0), "R9", "response bytes pushed", rcnt - rb, op[5] ? nch : 0);
    if (op[5]) begin
      bad = 0; fa = 0; fe = 0;
      for (int c = 0; c < nch; c++) begin
        e = 8'h00;
        for (int i = 0; i < nb; i++)
          e[op[3] ? 8 - nb + i : nb - 1 - i] = sbits[(sb + c * nb + i) % 4096];
        if (rmem[(rb + c) % 4096] !== e && bad == 0) begin
          fa = int'(rmem[(rb + c) % 4096]); fe = int'(e);
        end
        if (rmem[(rb + c) % 4096] !== e) bad++;
      end
      chk(bad == 0, lab, "captured byte", fa, fe);
    end
    if (op[4]) begin
      bad = 0; fa = 0; fe = 0;
      for (int c = 0; c < nch; c++) begin
        p = pat(seed, c);
        for (int i = 0; i < nb; i++) begin
          if (rxbits[(xb + c * nb + i) % 4096] !== (op[3] ? p[i] : p[7 - i])) begin
            if (bad == 0) begin fa = c * nb + i; fe = int'(p); end
            bad++;
          end
        end
      end
      chk(bad == 0, lab, "serial out bit index / payload", fa, fe);
      if (op[0]) chk(rise_chg - rc0 == 0, "R5", "sdo changes on rising edge", rise_chg - rc0, 0);
      else chk(fall_chg - fc0 + idle_chg - ic0 == 0, "R5", "sdo changes off rising edge",
               fall_chg - fc0 + idle_chg - ic0, 0);
    end else begin
      chk(sdo_hi - sh0 == 0, "R8", "sdo high with output disabled", sdo_hi - sh0, 0);
    end
    chk(done_cnt - d0 == 1, "R12", "done pulse cycles", done_cnt - d0, 1);
  endtask

  task automatic t_reset;
    chk(sclk === 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(sdo === 1'b0, "R1", "sdo in reset", sdo, 0);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", busy, 0);
    chk(cmd_pop === 1'b0 && rsp_push === 1'b0, "R1", "fifo strobes in reset", cmd_pop, 0);
  endtask

  task automatic t_send_fall;      do_cmd(8'h11, 16'd3, 1, "R5", 1'b0); endtask
  task automatic t_duplex;         do_cmd(8'h31, 16'd2, 2, "R6", 1'b0); endtask
  task automatic t_in_fall_lsb;    do_cmd(8'h2C, 16'd1, 3, "R6", 1'b0); endtask
  task automatic t_out_rise_lsb;   do_cmd(8'h18, 16'd1, 4, "R7", 1'b0); endtask
  task automatic t_duplex_lsb;     do_cmd(8'h3D, 16'd2, 5, "R7", 1'b0); endtask
  task automatic t_bits_msb;       do_cmd(8'h33, 16'h00F4, 6, "R10", 1'b0); endtask
  task automatic t_bits_lsb;       do_cmd(8'h3E, 16'd2, 7, "R10", 1'b0); endtask
  task automatic t_bits_full;      do_cmd(8'h12, 16'd7, 8, "R3", 1'b0); endtask
  task automatic t_bits_one_in;    do_cmd(8'h22, 16'd0, 9, "R3", 1'b0); endtask
  task automatic t_single;         do_cmd(8'h11, 16'd0, 10, "R2", 1'b0); endtask
  task automatic t_long;           do_cmd(8'h31, 16'h0100, 11, "R2", 1'b0); endtask
  task automatic t_busy;           do_cmd(8'h11, 16'd3, 12, "R12", 1'b1); endtask

  task automatic t_stall;
    stall_cmd = 1'b1;
    stall_rsp = 1'b1;
    do_cmd(8'h31, 16'd5, 13, "R11", 1'b0);
    do_cmd(8'h3A, 16'd5, 14, "R11", 1'b0);
    stall_cmd = 1'b0;
    stall_rsp = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin sbits[i] = 1'b0; cmem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_send_fall;
    t_duplex;
    t_in_fall_lsb;
    t_out_rise_lsb;
    t_duplex_lsb;
    t_bits_msb;
    t_bits_lsb;
    t_bits_full;
    t_bits_one_in;
    t_single;
    t_long;
    t_stall;
    t_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule